// File: doc/BRIEF.md
# Configurable UART serial framer

This block turns bytes into asynchronous serial frames and turns serial frames back into bytes. A single 16-bit divisor sets the baud rate: every bit lasts sixteen oversample ticks, and one tick lasts (divisor + 1) clocks, so the divisor is written as the wanted clock count per tick minus one. An 8-bit configuration byte selects 7 or 8 data bits, 1 or 2 stop bits, and no, even or odd parity. Bits 0, 1, 2 and 4 carry these controls. The remaining bits are ignored.

The transmit side takes bytes from a byte source through a valid/ready handshake. It shifts each frame out least significant bit first on a line that idles high. When the source already holds the next byte, the next frame follows the last stop bit with no gap. The receive side synchronises the incoming line and looks for a falling edge. It confirms the start bit at mid-bit and samples every later bit at its centre. It then presents each byte for one cycle, with a parity-error flag and a framing-error flag. A status output tells whether the transmitter has nothing left to shift.

Top module: `uart_framer`

## Requirements
- R1: Every transmitted bit, start bit included, lasts exactly 16 × (D + 1) clocks, where D = {div_hi, div_lo}. The supported range of D is 15 to 65535, and the high byte takes part in the period.
- R2: cfg bit 0 = 1 selects 8 data bits and cfg bit 0 = 0 selects 7 data bits. Data goes out least significant bit first. In 7-bit mode tx_data[7] is ignored and rx_data[7] reads 0.
- R3: cfg bit 1 = 1 sends two high stop bits and cfg bit 1 = 0 sends one.
- R4: cfg bit 2 = 1 inserts a parity bit straight after the data bits. cfg bit 4 = 0 makes the ones in data plus parity even, and cfg bit 4 = 1 makes them odd. cfg bits 3, 5, 6 and 7 have no effect.
- R5: The line idles high. A byte is taken on a clock edge where tx_valid and tx_ready are both high. The start bit (low) is driven from that edge on, and the configuration is captured at that edge.
- R6: tx_ready is high in the last clock of the last stop bit. A byte offered then starts its start bit on the very next clock, with no idle time.
- R7: tx_idle is low from the acceptance edge until the last stop bit has completed, and high otherwise.
- R8: The receiver arms on a falling edge of the synchronised line and confirms the start bit low 8 ticks later. A low pulse shorter than that produces no byte. Each confirmed frame gives exactly one single-cycle rx_valid pulse, carrying the byte assembled from mid-bit samples.
- R9: rx_parity_err is set when parity is enabled and the received parity bit disagrees with the selected sense. It is always 0 when parity is disabled.
- R10: rx_frame_err is set when the first stop bit samples low.
- R11: In reset, tx_line = 1, tx_idle = 1, tx_ready = 1 and rx_valid = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| div_lo | input | 8 | Low byte of the divisor (clocks per tick minus one) |
| div_hi | input | 8 | High byte of the divisor |
| cfg | input | 8 | Frame configuration byte |
| tx_valid | input | 1 | Byte source has a byte |
| tx_data | input | 8 | Byte to send |
| tx_ready | output | 1 | Transmitter takes the byte on this edge if valid |
| tx_line | output | 1 | Serial output, idle high |
| tx_idle | output | 1 | Nothing being shifted |
| rx_line | input | 1 | Serial input (asynchronous) |
| rx_valid | output | 1 | One-cycle pulse: a byte was received |
| rx_data | output | 8 | Received byte |
| rx_parity_err | output | 1 | Parity mismatch on this byte |
| rx_frame_err | output | 1 | First stop bit sampled low |

## Verification
The assertions assume that the divisor and the configuration are stable for as long as a frame is in flight on either side. The stimulus therefore changes them only after the transmitter has reported idle and the receiver has delivered its byte. The tick-spacing property also assumes a divisor greater than zero. Every divisor used lies in the supported range of 15 to 65535. The receive-side properties assume that rx_line changes no faster than the clock. The bench drives it at negative edges, either from tx_line or from its own frames, which are built bit by bit.

// File: rtl/uart_framer_pkg.sv
package uart_framer_pkg;

  localparam int CFG_LEN8_BIT   = 0;
  localparam int CFG_STOP2_BIT  = 1;
  localparam int CFG_PAREN_BIT  = 2;
  localparam int CFG_PARODD_BIT = 4;
  localparam int FRAME_BITS_MAX = 12;
  localparam int FRAME_CNT_W    = $clog2(FRAME_BITS_MAX + 1);

  typedef struct packed {
    logic len8;
    logic stop2;
    logic par_en;
    logic par_odd;
  } frame_cfg_t;

  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_BITS} rx_state_t;

  function automatic frame_cfg_t decode_cfg(input logic [7:0] c);
    frame_cfg_t f;
    f.len8    = c[CFG_LEN8_BIT];
    f.stop2   = c[CFG_STOP2_BIT];
    f.par_en  = c[CFG_PAREN_BIT];
    f.par_odd = c[CFG_PARODD_BIT];
    return f;
  endfunction

  function automatic logic [FRAME_CNT_W-1:0] data_bits(input frame_cfg_t f);
    return f.len8 ? FRAME_CNT_W'(8) : FRAME_CNT_W'(7);
  endfunction

  // start + data + parity + stop(s)
  function automatic logic [FRAME_CNT_W-1:0] frame_bits(input frame_cfg_t f);
    return FRAME_CNT_W'(1) + data_bits(f) + FRAME_CNT_W'(f.par_en)
           + (f.stop2 ? FRAME_CNT_W'(2) : FRAME_CNT_W'(1));
  endfunction

  function automatic logic parity_of(input logic [7:0] d, input frame_cfg_t f);
    logic [7:0] m;
    m = f.len8 ? d : {1'b0, d[6:0]};
    return (^m) ^ f.par_odd;
  endfunction

  // Bit 0 leaves the wire first; unused upper positions stay high (stop level).
  function automatic logic [FRAME_BITS_MAX-1:0] build_frame(input logic [7:0] d,
                                                            input frame_cfg_t f);
    logic [FRAME_BITS_MAX-1:0] fr;
    logic p;
    p      = parity_of(d, f);
    fr     = '1;
    fr[0]  = 1'b0;
    fr[7:1] = d[6:0];
    if (f.len8) begin
      fr[8] = d[7];
      if (f.par_en) fr[9] = p;
    end else if (f.par_en) begin
      fr[8] = p;
    end
    return fr;
  endfunction

endpackage

// File: rtl/uart_baud_gen.sv
module uart_baud_gen #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  assign tick = (cnt == div);

  always_ff @(posedge clk) begin
    if (!rst_n)            cnt <= '0;
    else if (clear || tick) cnt <= '0;
    else                   cnt <= cnt + 1'b1;
  end

  // R1: ticks are spaced by div+1 clocks, never back to back
  p_tick_gap_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && div != '0) |=> !tick);

endmodule

// File: rtl/uart_tx.sv
module uart_tx
  import uart_framer_pkg::*;
#(
  parameter int OS = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic [7:0] cfg_byte,
  input  logic       tx_valid,
  input  logic [7:0] tx_data,
  output logic       tx_ready,
  output logic       load,
  output logic       tx_line,
  output logic       tx_idle
);
  localparam int OS_W = $clog2(OS);

  logic                      active;
  logic [FRAME_BITS_MAX-1:0] shreg;
  logic [FRAME_CNT_W-1:0]    bits_left;
  logic [OS_W-1:0]           os;
  logic                      bit_end;
  logic                      frame_end;
  frame_cfg_t                fcfg;

  assign fcfg      = decode_cfg(cfg_byte);
  assign bit_end   = active && tick && (os == OS_W'(OS - 1));
  assign frame_end = bit_end && (bits_left == FRAME_CNT_W'(1));
  assign tx_ready  = !active || frame_end;
  assign load      = tx_valid && tx_ready;
  assign tx_line   = shreg[0];
  assign tx_idle   = !active;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active    <= 1'b0;
      shreg     <= '1;
      bits_left <= '0;
      os        <= '0;
    end else if (load) begin
      active    <= 1'b1;
      shreg     <= build_frame(tx_data, fcfg);
      bits_left <= frame_bits(fcfg);
      os        <= '0;
    end else if (frame_end) begin
      active    <= 1'b0;
      shreg     <= '1;
      bits_left <= '0;
      os        <= '0;
    end else if (bit_end) begin
      shreg     <= {1'b1, shreg[FRAME_BITS_MAX-1:1]};
      bits_left <= bits_left - 1'b1;
      os        <= '0;
    end else if (active && tick) begin
      os        <= os + 1'b1;
    end
  end

  // R5: an accepted byte drives the start bit from the next cycle
  p_start_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> !tx_line);
  // R7: transmitter reports busy right after acceptance
  p_busy_after_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> !tx_idle);
  // R1: the line only moves on a bit boundary
  p_hold_between_ticks_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !tick) |=> $stable(tx_line));
  // R6: a byte waiting at the frame end continues without an idle gap
  p_back_to_back_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end && tx_valid) |=> (!tx_idle && !tx_line));

endmodule

// File: rtl/uart_rx.sv
module uart_rx
  import uart_framer_pkg::*;
#(
  parameter int OS = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic [7:0] cfg_byte,
  input  logic       rx_line,
  output logic       clear,
  output logic       rx_valid,
  output logic [7:0] rx_data,
  output logic       rx_parity_err,
  output logic       rx_frame_err
);
  localparam int OS_W = $clog2(OS);

  logic                   s1, s2, s3;
  rx_state_t              st;
  frame_cfg_t             fcfg;
  logic [OS_W-1:0]        os;
  logic [FRAME_CNT_W-1:0] idx;
  logic [FRAME_CNT_W-1:0] nd;
  logic [7:0]             shd;
  logic                   parbit;
  logic                   fall;
  logic                   mid_start;
  logic                   mid_bit;
  logic [7:0]             dout;

  assign fall      = (st == RX_IDLE) && s3 && !s2;
  assign clear     = fall;
  assign mid_start = (st == RX_START) && tick && (os == OS_W'(OS / 2 - 1));
  assign mid_bit   = (st == RX_BITS) && tick && (os == OS_W'(OS - 1));
  assign nd        = data_bits(fcfg);
  assign dout      = fcfg.len8 ? shd : {1'b0, shd[7:1]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1 <= 1'b1;
      s2 <= 1'b1;
      s3 <= 1'b1;
    end else begin
      s1 <= rx_line;
      s2 <= s1;
      s3 <= s2;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st            <= RX_IDLE;
      fcfg          <= '0;
      os            <= '0;
      idx           <= '0;
      shd           <= '0;
      parbit        <= 1'b0;
      rx_valid      <= 1'b0;
      rx_data       <= '0;
      rx_parity_err <= 1'b0;
      rx_frame_err  <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      case (st)
        RX_IDLE: begin
          if (fall) begin
            st   <= RX_START;
            fcfg <= decode_cfg(cfg_byte);
            os   <= '0;
          end
        end
        RX_START: begin
          if (mid_start) begin
            os  <= '0;
            idx <= '0;
            st  <= s2 ? RX_IDLE : RX_BITS;
          end else if (tick) begin
            os <= os + 1'b1;
          end
        end
        RX_BITS: begin
          if (mid_bit) begin
            os  <= '0;
            idx <= idx + 1'b1;
            if (idx < nd) begin
              shd <= {s2, shd[7:1]};
            end else if (fcfg.par_en && idx == nd) begin
              parbit <= s2;
            end else begin
              st            <= RX_IDLE;
              rx_valid      <= 1'b1;
              rx_data       <= dout;
              rx_parity_err <= fcfg.par_en && (parbit != parity_of(dout, fcfg));
              rx_frame_err  <= !s2;
            end
          end else if (tick) begin
            os <= os + 1'b1;
          end
        end
        default: st <= RX_IDLE;
      endcase
    end
  end

  // R8: each received byte is flagged for exactly one cycle
  p_valid_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);
  // R9: no parity error can be reported for a frame without parity
  p_no_parity_no_err_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !fcfg.par_en) |-> !rx_parity_err);
  // R10: framing flag mirrors the synchronised line at the stop sample
  p_frame_err_stop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> (rx_frame_err == !$past(s2)));
  // R8: a frame is only accepted after the start bit was confirmed low
  p_confirm_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mid_start && s2) |=> (st == RX_IDLE));

endmodule

// File: rtl/uart_framer.sv
module uart_framer #(
  parameter int DIV_W = 16,
  parameter int OS    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [7:0]        div_lo,
  input  logic [DIV_W-9:0]  div_hi,
  input  logic [7:0]        cfg,
  input  logic              tx_valid,
  input  logic [7:0]        tx_data,
  output logic              tx_ready,
  output logic              tx_line,
  output logic              tx_idle,
  input  logic              rx_line,
  output logic              rx_valid,
  output logic [7:0]        rx_data,
  output logic              rx_parity_err,
  output logic              rx_frame_err
);
  logic [DIV_W-1:0] div;
  logic             tx_tick, tx_load;
  logic             rx_tick, rx_clear;

  assign div = {div_hi, div_lo};

  uart_baud_gen #(.DIV_W(DIV_W)) u_tx_baud (
    .clk(clk), .rst_n(rst_n), .clear(tx_load), .div(div), .tick(tx_tick)
  );

  uart_baud_gen #(.DIV_W(DIV_W)) u_rx_baud (
    .clk(clk), .rst_n(rst_n), .clear(rx_clear), .div(div), .tick(rx_tick)
  );

  uart_tx #(.OS(OS)) u_tx (
    .clk(clk), .rst_n(rst_n), .tick(tx_tick), .cfg_byte(cfg),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
    .load(tx_load), .tx_line(tx_line), .tx_idle(tx_idle)
  );

  uart_rx #(.OS(OS)) u_rx (
    .clk(clk), .rst_n(rst_n), .tick(rx_tick), .cfg_byte(cfg),
    .rx_line(rx_line), .clear(rx_clear), .rx_valid(rx_valid),
    .rx_data(rx_data), .rx_parity_err(rx_parity_err),
    .rx_frame_err(rx_frame_err)
  );

endmodule

// File: tb/uart_framer_tb.sv
module uart_framer_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] div_lo, div_hi, cfg;
  logic       tx_valid;
  logic [7:0] tx_data;
  logic       tx_ready, tx_line, tx_idle;
  logic       rx_line;
  logic       rx_valid;
  logic [7:0] rx_data;
  logic       rx_parity_err, rx_frame_err;
  logic       loop_en;
  logic       drv_line;

  int n_chk = 0;
  int n_bad = 0;
  int rx_cnt = 0;
  logic [7:0] got_d;
  logic got_pe, got_fe;
  bit finished = 0;

  always #2 clk = ~clk;

  assign rx_line = loop_en ? tx_line : drv_line;

  uart_framer u_dut (
    .clk(clk), .rst_n(rst_n), .div_lo(div_lo), .div_hi(div_hi), .cfg(cfg),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
    .tx_line(tx_line), .tx_idle(tx_idle), .rx_line(rx_line),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_parity_err(rx_parity_err),
    .rx_frame_err(rx_frame_err)
  );

  always @(negedge clk) begin
    if (rx_valid) begin
      rx_cnt <= rx_cnt + 1;
      got_d  <= rx_data;
      got_pe <= rx_parity_err;
      got_fe <= rx_frame_err;
    end
  end

  task automatic check(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int bp();
    return 16 * (int'({div_hi, div_lo}) + 1);
  endfunction

  function automatic int nbits(input logic [7:0] c);
    return 1 + (c[0] ? 8 : 7) + int'(c[2]) + (c[1] ? 2 : 1);
  endfunction

  function automatic logic exp_bit(input logic [7:0] c, input logic [7:0] d, input int i);
    int nd;
    int ones;
    nd = c[0] ? 8 : 7;
    if (i == 0) return 1'b0;
    if (i <= nd) return d[i-1];
    if (c[2] && i == nd + 1) begin
      ones = $countones(d & (c[0] ? 8'hFF : 8'h7F));
      return c[4] ? (ones % 2 == 0) : (ones % 2 == 1);
    end
    return 1'b1;
  endfunction

  function automatic string bit_req(input logic [7:0] c, input int i);
    int nd;
    nd = c[0] ? 8 : 7;
    if (i == 0) return "R5";
    if (i <= nd) return "R2";
    if (c[2] && i == nd + 1) return "R4";
    return "R3";
  endfunction

  // Called at the first negedge after the acceptance edge; returns at mid last bit.
  task automatic check_bits(input logic [7:0] c, input logic [7:0] d);
    int nb;
    nb = nbits(c);
    repeat (bp() / 2) @(negedge clk);
    for (int i = 0; i < nb; i++) begin
      check(bit_req(c, i), $sformatf("tx bit %0d cfg=%0h d=%0h", i, c, d),
            int'(tx_line), int'(exp_bit(c, d, i)));
      if (i == 0) check("R7", "tx_idle low in frame", int'(tx_idle), 0);
      if (i < nb - 1) repeat (bp()) @(negedge clk);
    end
  endtask

  task automatic end_checks();
    repeat (bp() / 2 - 1) @(negedge clk);
    check("R1", "busy in last clock of frame", int'(tx_idle), 0);
    @(negedge clk);
    check("R1", "idle right after frame", int'(tx_idle), 1);
    check("R7", "line high after frame", int'(tx_line), 1);
  endtask

  task automatic rx_expect(input int base, input int n, input logic [7:0] c,
                           input logic [7:0] d, input logic pe, input logic fe);
    check("R8", "rx byte count", rx_cnt - base, n);
    check("R2", $sformatf("rx data cfg=%0h", c), int'(got_d),
          int'(c[0] ? d : (d & 8'h7F)));
    check("R9", "rx parity flag", int'(got_pe), int'(pe));
    check("R10", "rx frame flag", int'(got_fe), int'(fe));
  endtask

  task automatic send_one(input logic [7:0] c, input logic [7:0] d);
    int base;
    base = rx_cnt;
    cfg = c;
    @(negedge clk);
    tx_valid = 1'b1;
    tx_data  = d;
    while (!tx_ready) @(negedge clk);
    @(negedge clk);
    tx_valid = 1'b0;
    tx_data  = 8'h00;
    check_bits(c, d);
    end_checks();
    repeat (4) @(negedge clk);
    rx_expect(base, 1, c, d, 1'b0, 1'b0);
  endtask

  task automatic send_pair(input logic [7:0] c, input logic [7:0] a, input logic [7:0] b);
    int base;
    base = rx_cnt;
    cfg = c;
    @(negedge clk);
    tx_valid = 1'b1;
    tx_data  = a;
    while (!tx_ready) @(negedge clk);
    @(negedge clk);
    tx_data = b;
    check_bits(c, a);
    repeat (bp() / 2 - 1) @(negedge clk);
    check("R6", "ready in last clock", int'(tx_ready), 1);
    check("R3", "stop still high", int'(tx_line), 1);
    @(negedge clk);
    check("R6", "next start without gap", int'(tx_line), 0);
    check("R7", "still busy across frames", int'(tx_idle), 0);
    tx_valid = 1'b0;
    check_bits(c, b);
    end_checks();
    repeat (4) @(negedge clk);
    rx_expect(base, 2, c, b, 1'b0, 1'b0);
  endtask

  task automatic drive_frame(input logic [7:0] c, input logic [7:0] d,
                             input logic flip_par, input logic bad_stop);
    int nb;
    int nd;
    logic b;
    nb = nbits(c);
    nd = c[0] ? 8 : 7;
    cfg = c;
    for (int i = 0; i < nb; i++) begin
      b = exp_bit(c, d, i);
      if (flip_par && c[2] && i == nd + 1) b = ~b;
      if (bad_stop && i == nd + 1 + int'(c[2])) b = 1'b0;
      @(negedge clk);
      drv_line = b;
      repeat (bp() - 1) @(negedge clk);
    end
    @(negedge clk);
    drv_line = 1'b1;
    repeat (bp()) @(negedge clk);
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 180000, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int base;
    logic [7:0] c, d;
    rst_n = 1'b0; tx_valid = 1'b0; tx_data = 8'h00; loop_en = 1'b1;
    drv_line = 1'b1; div_lo = 8'd15; div_hi = 8'd0; cfg = 8'h00;
    repeat (5) @(negedge clk);
    check("R11", "reset tx_line", int'(tx_line), 1);
    check("R11", "reset tx_idle", int'(tx_idle), 1);
    check("R11", "reset tx_ready", int'(tx_ready), 1);
    check("R11", "reset rx_valid", int'(rx_valid), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // Sweep all 12 frame formats; odd indexes add ignored cfg bits (R4)
    for (int k = 0; k < 12; k++) begin
      c = {3'b000, (k / 4 == 2), 1'b0, (k / 4 != 0), k[1], k[0]};
      if (k % 2 == 1) c = c | 8'hE8;
      d = 8'(k * 37 + 5);
      send_one(c, d | 8'h80);
      send_one(c, ~d);
    end

    // Back-to-back frames, 8 data, 2 stop, odd parity
    send_pair(8'h17, 8'hA5, 8'h3C);

    // Divisor with high byte set (R1): 16*(256+1) clocks per bit
    div_hi = 8'd1; div_lo = 8'd0;
    send_one(8'h00, 8'h4B);
    div_hi = 8'd0; div_lo = 8'd15;

    // Receiver error cases, bench drives the line
    loop_en = 1'b0;
    repeat (4) @(negedge clk);
    base = rx_cnt;
    drive_frame(8'h05, 8'h96, 1'b1, 1'b0);
    rx_expect(base, 1, 8'h05, 8'h96, 1'b1, 1'b0);
    base = rx_cnt;
    drive_frame(8'h14, 8'h21, 1'b1, 1'b0);
    rx_expect(base, 1, 8'h14, 8'h21, 1'b1, 1'b0);
    base = rx_cnt;
    drive_frame(8'h01, 8'h5A, 1'b0, 1'b1);
    rx_expect(base, 1, 8'h01, 8'h5A, 1'b0, 1'b1);
    base = rx_cnt;
    drive_frame(8'h15, 8'hC3, 1'b0, 1'b1);
    rx_expect(base, 1, 8'h15, 8'hC3, 1'b0, 1'b1);

    // Short low pulse must not produce a byte (R8)
    base = rx_cnt;
    @(negedge clk);
    drv_line = 1'b0;
    repeat (bp() / 4) @(negedge clk);
    drv_line = 1'b1;
    repeat (2 * bp()) @(negedge clk);
    check("R8", "glitch rejected", rx_cnt - base, 0);
    base = rx_cnt;
    drive_frame(8'h04, 8'h7E, 1'b0, 1'b0);
    rx_expect(base, 1, 8'h04, 8'h7E, 1'b0, 1'b0);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule